// File: doc/BRIEF.md
# Sync Timing Validator with Lock

This block sits in the digital part of a video front end, behind the analog sync slicer. It receives a separated horizontal sync pulse train and a vertical sync pulse train, both already digital, together with a fast sampling clock. It measures every horizontal line: the number of clocks from one leading edge to the next, and how long the pulse stays active. It then decides whether that line is good. A good line has its period inside the legal line-rate window and a pulse width inside a window expressed as a fraction of the measured period.

A lock flag rises once three good lines have arrived in a row. It falls on the first bad line, and also when the horizontal edges stop arriving. The vertical pulse is judged on two things: its length, counted in horizontal lines, and the field rate, taken as the spacing between vertical leading edges. The field verdict is published when each vertical pulse ends.

A parameter selects the width rule. Bi-level sync has both a lower and an upper width limit. Tri-level sync has only a lower limit. A second parameter sets the active level of the two sync inputs.

Top module: `sync_timing_validator`

## Requirements
- R1: A line is good only if its period P, in clocks between consecutive horizontal leading edges, satisfies CLK_HZ/150000 <= P <= CLK_HZ/10750 (integer division). With CLK_HZ = 1 MHz this is 6 to 93 clocks.
- R2: With bi-level width rules, the width W of a good line, in clocks the synchronized pulse stays active from its leading edge, satisfies W*1000 >= P*30 and W*1000 <= P*128. This is 3 % to 12.8 % of the period.
- R3: With tri-level width rules there is no upper width limit, and a good line needs only W*1000 >= P*14.
- R4: Each judged line gives a one-cycle `lineDone` strobe, with `lineGood` showing the verdict. The strobe comes one clock after the internal detection of the edge that closes the line. `lineLocked` is high exactly when the last three judged lines were all good.
- R5: A bad line clears the run of good lines, so `lineLocked` is low in the same cycle as that line's `lineDone` strobe.
- R6: If MAX = CLK_HZ/10750 clocks pass after a leading edge with no further edge, the line is reported as bad and lock drops. The next edge only opens a new line and is not judged.
- R7: A vertical pulse has the right length only if it holds between 2 and 7 horizontal leading edges. An edge that coincides with the vertical leading edge counts. An edge seen when the vertical input has already gone inactive does not count.
- R8: The field rate is valid only if the spacing between the current and the previous vertical leading edge lies between CLK_HZ/100 and CLK_HZ/23 clocks. The first field after reset is always invalid.
- R9: `fieldValid` changes only together with a one-cycle `fieldDone` strobe, issued one clock after the vertical trailing edge is detected. It equals rate-valid AND length-valid.
- R10: Both inputs pass through a two-flop synchronizer. `ACTIVE_LOW` = 1 treats a low level as the sync pulse, and 0 treats a high level as the pulse.
- R11: A synchronous active-high `rst` clears all counters and flags, and holds `lineDone`, `lineLocked`, `fieldDone` and `fieldValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| hSyncIn | input | 1 | Horizontal sync, asynchronous |
| vSyncIn | input | 1 | Vertical sync, asynchronous |
| lineDone | output | 1 | One-cycle strobe per judged line |
| lineGood | output | 1 | Verdict of the line reported by `lineDone` |
| lineLocked | output | 1 | Three consecutive good lines seen |
| fieldDone | output | 1 | One-cycle strobe after each vertical pulse ends |
| fieldValid | output | 1 | Last field had legal length and rate |

## Verification
Two events can land in the same clock.

The first pair is a horizontal leading edge and a vertical leading edge. The bench aligns every vertical pulse with a line start, so the length counter must count the coinciding edge. The bench then scores each field verdict against lengths of 1, 2, 3, 7 and 8 lines.

The second pair is the vertical trailing edge and the next horizontal leading edge. These also fall together, and the edge must not be counted. The bench catches a wrong count here as a failed field verdict at the 7-line and 8-line limits.

// File: rtl/syncval_pkg.sv
package syncval_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic lineStart;
    logic fieldStart;
  } ctlStrobe_t;

  // measurements from datapath to control
  typedef struct packed {
    logic hLead;
    logic vLead;
    logic vTrail;
    logic periodOk;
    logic widthOk;
    logic periodAtMax;
    logic fieldRateOk;
    logic vLinesOk;
  } dpStat_t;

endpackage

// File: rtl/sv_edge_sync.sv
module sv_edge_sync #(
  parameter bit ACTIVE_LOW = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic level,
  output logic lead,
  output logic trail
);
  logic activeRaw;
  logic meta, stable, prevLevel;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign activeRaw = ~rawIn;
    end else begin : g_high
      assign activeRaw = rawIn;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      meta      <= 1'b0;
      stable    <= 1'b0;
      prevLevel <= 1'b0;
    end else begin
      meta      <= activeRaw;
      stable    <= meta;
      prevLevel <= stable;
    end
  end

  assign level = stable;
  assign lead  = stable & ~prevLevel;
  assign trail = ~stable & prevLevel;
endmodule

// File: rtl/sv_datapath.sv
module sv_datapath
  import syncval_pkg::*;
#(
  parameter int CLK_HZ       = 1_000_000,
  parameter int MIN_LINE_HZ  = 10_750,
  parameter int MAX_LINE_HZ  = 150_000,
  parameter int MIN_FIELD_HZ = 23,
  parameter int MAX_FIELD_HZ = 100,
  parameter int MIN_VLINES   = 2,
  parameter int MAX_VLINES   = 7,
  parameter bit TRI_LEVEL    = 1'b0,
  parameter bit ACTIVE_LOW   = 1'b1,
  parameter int PM_SCALE     = 1000,
  parameter int BI_MIN_PM    = 30,
  parameter int BI_MAX_PM    = 128,
  parameter int TRI_MIN_PM   = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hRaw,
  input  logic       vRaw,
  input  ctlStrobe_t ctl,
  output dpStat_t    stat
);
  localparam int MIN_PERIOD = CLK_HZ / MAX_LINE_HZ;
  localparam int MAX_PERIOD = CLK_HZ / MIN_LINE_HZ;
  localparam int MIN_FIELD  = CLK_HZ / MAX_FIELD_HZ;
  localparam int MAX_FIELD  = CLK_HZ / MIN_FIELD_HZ;
  localparam int PW         = $clog2(MAX_PERIOD + 1);
  localparam int FW         = $clog2(MAX_FIELD + 2);
  localparam int VW         = $clog2(MAX_VLINES + 2);
  localparam int PROD_W     = PW + $clog2(PM_SCALE + 1) + 1;
  localparam int LO_PM      = TRI_LEVEL ? TRI_MIN_PM : BI_MIN_PM;

  logic hLevel, hLead, hTrail, vLevel, vLead, vTrail;

  sv_edge_sync #(.ACTIVE_LOW(ACTIVE_LOW)) u_hSync (
    .clk(clk), .rst(rst), .rawIn(hRaw), .level(hLevel), .lead(hLead), .trail(hTrail));
  sv_edge_sync #(.ACTIVE_LOW(ACTIVE_LOW)) u_vSync (
    .clk(clk), .rst(rst), .rawIn(vRaw), .level(vLevel), .lead(vLead), .trail(vTrail));

  logic [PW-1:0] periodCnt, widthCnt;
  logic          inPulse;
  logic [FW-1:0] fieldCnt;
  logic [VW-1:0] vLines;

  // line period and pulse width counters
  always_ff @(posedge clk) begin
    if (rst) begin
      periodCnt <= '0;
      widthCnt  <= '0;
      inPulse   <= 1'b0;
    end else if (ctl.lineStart) begin
      periodCnt <= PW'(1);
      widthCnt  <= PW'(1);
      inPulse   <= 1'b1;
    end else begin
      if (periodCnt < PW'(MAX_PERIOD)) periodCnt <= periodCnt + 1'b1;
      if (hTrail) inPulse <= 1'b0;
      else if (inPulse && hLevel && widthCnt < PW'(MAX_PERIOD)) widthCnt <= widthCnt + 1'b1;
    end
  end

  // field spacing and vertical length in lines
  always_ff @(posedge clk) begin
    if (rst) begin
      fieldCnt <= '0;
      vLines   <= '0;
    end else if (ctl.fieldStart) begin
      fieldCnt <= FW'(1);
      vLines   <= VW'(hLead);
    end else begin
      if (fieldCnt <= FW'(MAX_FIELD)) fieldCnt <= fieldCnt + 1'b1;
      if (hLead && vLevel && vLines <= VW'(MAX_VLINES)) vLines <= vLines + 1'b1;
    end
  end

  // width against fractions of the period, no divider
  logic [PROD_W-1:0] widthScaled, loBound, hiBound;
  logic              loOk, widthOk;
  assign widthScaled = {{(PROD_W-PW){1'b0}}, widthCnt} * PROD_W'(PM_SCALE);
  assign loBound     = {{(PROD_W-PW){1'b0}}, periodCnt} * PROD_W'(LO_PM);
  assign hiBound     = {{(PROD_W-PW){1'b0}}, periodCnt} * PROD_W'(BI_MAX_PM);
  assign loOk        = widthScaled >= loBound;

  generate
    if (TRI_LEVEL) begin : g_tri
      assign widthOk = loOk;
    end else begin : g_bi
      assign widthOk = loOk && (widthScaled <= hiBound);
    end
  endgenerate

  always_comb begin
    stat.hLead       = hLead;
    stat.vLead       = vLead;
    stat.vTrail      = vTrail;
    stat.periodOk    = (periodCnt >= PW'(MIN_PERIOD)) && (periodCnt <= PW'(MAX_PERIOD));
    stat.widthOk     = widthOk;
    stat.periodAtMax = (periodCnt == PW'(MAX_PERIOD));
    stat.fieldRateOk = (fieldCnt >= FW'(MIN_FIELD)) && (fieldCnt <= FW'(MAX_FIELD));
    stat.vLinesOk    = (vLines >= VW'(MIN_VLINES)) && (vLines <= VW'(MAX_VLINES));
  end

  // R1
  period_sat_chk: assert property (@(posedge clk) disable iff (rst)
    periodCnt <= PW'(MAX_PERIOD));

  // R7
  vlines_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!vLevel && !ctl.fieldStart) |=> $stable(vLines));
endmodule

// File: rtl/sv_control.sv
module sv_control
  import syncval_pkg::*;
#(
  parameter int GOOD_LINES = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  dpStat_t    stat,
  output ctlStrobe_t ctl,
  output logic       lineDone,
  output logic       lineGood,
  output logic       lineLocked,
  output logic       fieldDone,
  output logic       fieldValid
);
  localparam int GCW = $clog2(GOOD_LINES + 1);

  logic           hasRef, havePrevV, rateOkHeld;
  logic [GCW-1:0] goodCnt;
  logic           lineOk, timeoutHit;

  assign lineOk     = stat.periodOk && stat.widthOk;
  assign timeoutHit = hasRef && stat.periodAtMax && !stat.hLead;

  always_comb begin
    ctl.lineStart  = stat.hLead;
    ctl.fieldStart = stat.vLead;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hasRef     <= 1'b0;
      goodCnt    <= '0;
      lineDone   <= 1'b0;
      lineGood   <= 1'b0;
      havePrevV  <= 1'b0;
      rateOkHeld <= 1'b0;
      fieldDone  <= 1'b0;
      fieldValid <= 1'b0;
    end else begin
      lineDone  <= 1'b0;
      fieldDone <= 1'b0;
      if (stat.hLead) begin
        hasRef <= 1'b1;
        if (hasRef) begin
          lineDone <= 1'b1;
          lineGood <= lineOk;
          if (!lineOk) goodCnt <= '0;
          else if (goodCnt < GCW'(GOOD_LINES)) goodCnt <= goodCnt + 1'b1;
        end
      end else if (timeoutHit) begin
        hasRef   <= 1'b0;
        lineDone <= 1'b1;
        lineGood <= 1'b0;
        goodCnt  <= '0;
      end
      if (stat.vLead) begin
        havePrevV  <= 1'b1;
        rateOkHeld <= havePrevV && stat.fieldRateOk;
      end
      if (stat.vTrail) begin
        fieldDone  <= 1'b1;
        fieldValid <= rateOkHeld && stat.vLinesOk;
      end
    end
  end

  assign lineLocked = (goodCnt == GCW'(GOOD_LINES));

  // R5
  bad_line_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (lineDone && !lineGood) |-> !lineLocked);

  // R4
  lock_needs_good_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lineLocked) |-> (lineDone && lineGood));

  // R6
  timeout_report_chk: assert property (@(posedge clk) disable iff (rst)
    timeoutHit |=> (lineDone && !lineGood && !lineLocked));

  // R9
  field_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(fieldValid) |-> fieldDone);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!lineLocked && !lineDone && !fieldDone && !fieldValid));
endmodule

// File: rtl/sync_timing_validator.sv
module sync_timing_validator
  import syncval_pkg::*;
#(
  parameter int CLK_HZ       = 1_000_000,
  parameter int MIN_LINE_HZ  = 10_750,
  parameter int MAX_LINE_HZ  = 150_000,
  parameter int MIN_FIELD_HZ = 23,
  parameter int MAX_FIELD_HZ = 100,
  parameter int MIN_VLINES   = 2,
  parameter int MAX_VLINES   = 7,
  parameter int GOOD_LINES   = 3,
  parameter bit TRI_LEVEL    = 1'b0,
  parameter bit ACTIVE_LOW   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic hSyncIn,
  input  logic vSyncIn,
  output logic lineDone,
  output logic lineGood,
  output logic lineLocked,
  output logic fieldDone,
  output logic fieldValid
);
  ctlStrobe_t ctl;
  dpStat_t    stat;

  sv_datapath #(
    .CLK_HZ(CLK_HZ), .MIN_LINE_HZ(MIN_LINE_HZ), .MAX_LINE_HZ(MAX_LINE_HZ),
    .MIN_FIELD_HZ(MIN_FIELD_HZ), .MAX_FIELD_HZ(MAX_FIELD_HZ),
    .MIN_VLINES(MIN_VLINES), .MAX_VLINES(MAX_VLINES),
    .TRI_LEVEL(TRI_LEVEL), .ACTIVE_LOW(ACTIVE_LOW)
  ) u_datapath (
    .clk(clk), .rst(rst), .hRaw(hSyncIn), .vRaw(vSyncIn), .ctl(ctl), .stat(stat));

  sv_control #(.GOOD_LINES(GOOD_LINES)) u_control (
    .clk(clk), .rst(rst), .stat(stat), .ctl(ctl),
    .lineDone(lineDone), .lineGood(lineGood), .lineLocked(lineLocked),
    .fieldDone(fieldDone), .fieldValid(fieldValid));
endmodule

// File: tb/sync_timing_validator_tb.sv
module sync_timing_validator_tb;
  localparam int CLK_HZ = 1_000_000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic hL = 1'b0, vL = 1'b0;
  logic aDone, aGood, aLock, aFDone, aFValid;
  logic bDone, bGood, bLock, bFDone, bFValid;

  // bi-level, active-low inputs
  sync_timing_validator #(.CLK_HZ(CLK_HZ), .TRI_LEVEL(1'b0), .ACTIVE_LOW(1'b1)) u_dut (
    .clk(clk), .rst(rst), .hSyncIn(~hL), .vSyncIn(~vL),
    .lineDone(aDone), .lineGood(aGood), .lineLocked(aLock),
    .fieldDone(aFDone), .fieldValid(aFValid));

  // tri-level, active-high inputs
  sync_timing_validator #(.CLK_HZ(CLK_HZ), .TRI_LEVEL(1'b1), .ACTIVE_LOW(1'b0)) u_dut_tri (
    .clk(clk), .rst(rst), .hSyncIn(hL), .vSyncIn(vL),
    .lineDone(bDone), .lineGood(bGood), .lineLocked(bLock),
    .fieldDone(bFDone), .fieldValid(bFValid));

  int errors = 0, checks = 0;
  bit expA[$], expB[$], expFA[$], expFB[$];
  string reqA[$], reqB[$], reqFA[$], reqFB[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: one line, expected verdicts pushed for both instances
  task automatic sendLine(input int period, input int width, input bit gA, input bit gB,
                          input string req, input bit vAct);
    expA.push_back(gA); reqA.push_back(req);
    expB.push_back(gB); reqB.push_back(req);
    hL = 1'b1; vL = vAct;
    repeat (width) @(negedge clk);
    hL = 1'b0;
    repeat (period - width) @(negedge clk);
  endtask

  task automatic sendField(input int nLines, input int vWidth, input bit ok, input string req);
    expFA.push_back(ok); reqFA.push_back(req);
    expFB.push_back(ok); reqFB.push_back(req);
    for (int i = 0; i < nLines; i++) sendLine(80, 5, 1'b1, 1'b1, "R4", i < vWidth);
  endtask

  // monitors: pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (aDone) begin
        if (expA.size() == 0) check(1'b0, "R4", "bi unexpected line report", 1, 0);
        else begin
          automatic bit e = expA.pop_front();
          automatic string r = reqA.pop_front();
          check(aGood == e, r, "bi line verdict", aGood, e);
        end
      end
      if (bDone) begin
        if (expB.size() == 0) check(1'b0, "R4", "tri unexpected line report", 1, 0);
        else begin
          automatic bit e = expB.pop_front();
          automatic string r = reqB.pop_front();
          check(bGood == e, r, "tri line verdict", bGood, e);
        end
      end
      if (aFDone) begin
        if (expFA.size() == 0) check(1'b0, "R9", "bi unexpected field report", 1, 0);
        else begin
          automatic bit e = expFA.pop_front();
          automatic string r = reqFA.pop_front();
          check(aFValid == e, r, "bi field verdict", aFValid, e);
        end
      end
      if (bFDone) begin
        if (expFB.size() == 0) check(1'b0, "R9", "tri unexpected field report", 1, 0);
        else begin
          automatic bit e = expFB.pop_front();
          automatic string r = reqFB.pop_front();
          check(bFValid == e, r, "tri field verdict", bFValid, e);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (199_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R11: cleared during reset
    check(!aLock && !aDone && !aFValid && !aFDone, "R11", "bi reset state", aLock, 0);
    check(!bLock && !bDone && !bFValid && !bFDone, "R11", "tri reset state", bLock, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R4 / R10: three good lines lock both polarities
    sendLine(80, 5, 1, 1, "R4", 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    check(!aLock, "R4", "bi lock after two judged", aLock, 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    check(aLock, "R4", "bi lock after three good", aLock, 1);
    check(bLock, "R10", "tri active-high lock", bLock, 1);

    // R2 / R3: too wide for bi, fine for tri
    sendLine(80, 11, 0, 1, "R2", 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    check(!aLock, "R5", "bi lock dropped by bad line", aLock, 0);
    check(bLock, "R3", "tri keeps lock on wide pulse", bLock, 1);
    sendLine(80, 2, 0, 1, "R2", 0);
    sendLine(80, 1, 0, 0, "R3", 0);
    sendLine(80, 10, 1, 1, "R2", 0);
    // R1: period edges
    sendLine(93, 5, 1, 1, "R1", 0);
    sendLine(6, 1, 0, 1, "R1", 0);
    sendLine(5, 1, 0, 0, "R1", 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    sendLine(80, 5, 1, 1, "R4", 0);
    sendLine(80, 5, 1, 1, "R4", 0);

    // R6: timeout line, checked mid-line
    expA.push_back(0); reqA.push_back("R6");
    expB.push_back(0); reqB.push_back("R6");
    hL = 1'b1;
    repeat (5) @(negedge clk);
    hL = 1'b0;
    repeat (60) @(negedge clk);
    check(aLock && bLock, "R4", "locked before timeout", aLock, 1);
    repeat (40) @(negedge clk);
    check(!aLock, "R6", "bi lock dropped on timeout", aLock, 0);
    check(!bLock, "R6", "tri lock dropped on timeout", bLock, 0);
    repeat (45) @(negedge clk);
    sendLine(80, 5, 1, 1, "R6", 0);
    sendLine(80, 5, 1, 1, "R6", 0);
    sendLine(80, 5, 1, 1, "R6", 0);
    check(!aLock, "R6", "edge after timeout not judged", aLock, 0);

    // R7 / R8 / R9: fields
    sendField(130, 3, 0, "R8");
    check(aLock && bLock, "R4", "locked during fields", aLock, 1);
    sendField(130, 3, 1, "R8");
    sendField(130, 1, 0, "R7");
    sendField(130, 8, 0, "R7");
    sendField(130, 7, 1, "R7");
    sendField(100, 2, 1, "R7");
    sendField(550, 3, 0, "R8");
    sendField(130, 3, 0, "R8");
    sendField(130, 2, 1, "R9");
    check(aFValid && bFValid, "R9", "field flag held", aFValid, 1);

    sendLine(200, 5, 0, 0, "R6", 0);
    repeat (10) @(negedge clk);
    check(expA.size() == 0 && expB.size() == 0, "R4", "all lines reported", expA.size(), 0);
    check(expFA.size() == 0 && expFB.size() == 0, "R9", "all fields reported", expFA.size(), 0);
    finishRun();
  end
endmodule